// File: doc/BRIEF.md
# SD SPI Multi-Block Transfer Sequencer

This block drives the command and token steps of a multi-block read or write to a memory card that has already been brought up in SPI mode. A host pulses a start strobe with a first block number, a block count, a direction select and the capacity class found during bring-up. The block then queries the card status, issues the multi-block data command and walks through each block's token exchange. It ends the transfer with a stop command for reads or a stop token for writes. The payload bytes and their CRC are moved by a separate data engine. This block only tells that engine when each 512-byte block starts, through a per-block strobe, and waits for its completion pulse.

Commands go out through a request/done handshake shared with the bring-up logic. The handshake carries a 6-bit index and a 32-bit argument, and the response comes back with the done pulse. Token bytes sent to the card use a valid/ready pair. Bytes received from the card are polled: while the sequencer raises a request, each valid byte is consumed. The states are IDLE, STAT (status query), XCMD (data command), RD_TOK (wait for read start token), BLK_GO (one-cycle block strobe), PAYLOAD (wait for the data engine), WR_TOK (send write start token), WR_RESP (wait for the data-response token), WR_BUSY (wait out card busy), STOP_CMD, STOP_TOK, STOP_BUSY and FINISH.

The transitions run as follows. IDLE goes to STAT on an accepted start, or to FINISH if the count is zero. STAT goes to XCMD when the status is ready. XCMD goes to RD_TOK or WR_TOK. RD_TOK goes to BLK_GO on a start token, and BLK_GO goes to PAYLOAD. On a read, PAYLOAD returns to RD_TOK, or goes to STOP_CMD after the last block. On a write, PAYLOAD goes to WR_RESP, then WR_BUSY. WR_BUSY returns to WR_TOK, or goes to STOP_TOK after the last block. STOP_TOK goes to STOP_BUSY. STOP_CMD and STOP_BUSY go to FINISH. Every failure jumps to FINISH with the error flag set, and FINISH returns to IDLE.

Top module: `sd_blk_xfer_seq`

## Requirements
- R1: A start strobe is accepted only in IDLE. A strobe seen while busy has no effect on the commands, tokens, block strobes or done pulses of the running transfer.
- R2: Every transfer begins with a status command (index 13, argument 0). It proceeds only if the whole 16-bit response is zero; otherwise it finishes with error and no further command is issued.
- R3: A read then issues index 18 and a write issues index 25. A nonzero low response byte (`cmd_resp_i[7:0]`) finishes with error.
- R4: The data command argument equals the block number for high-capacity cards. For standard cards it is the block number shifted left by 9, truncated to 32 bits.
- R5: Before each read block, 0xFF bytes are skipped until 0xFE arrives. Any other byte is an error. WAIT_LIMIT consecutive 0xFF bytes are an error, while WAIT_LIMIT-1 are tolerated.
- R6: Each write block is preceded by the token 0xFC on the token transmit port.
- R7: After each written block, 0xFF bytes are skipped. The first other byte is accepted when its bits [3:0] equal 0x5, whatever its upper bits; otherwise the transfer finishes with error.
- R8: After each data response and after the write stop token, 0x00 bytes mean busy and the first nonzero byte releases. WAIT_LIMIT consecutive 0x00 bytes are an error.
- R9: Exactly N block strobes are produced for a count of N, one per block, and the stop step follows the Nth block.
- R10: A read ends with a stop command (index 12, argument 0). A write ends with the token 0xFD.
- R11: `done_o` is a one-cycle pulse at the end of every accepted start. `busy_o` is high from acceptance through that pulse and low after it.
- R12: `error_o` rises together with `done_o` on a failure and holds until the next accepted start clears it. A count of zero finishes at once with error and issues no command.
- R13: At most one of command request, token transmit, byte receive request and block strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| write_i | input | 1 | 1 selects write, 0 selects read |
| high_cap_i | input | 1 | Card is high capacity (block addressing) |
| blk_num_i | input | ARG_W | First block number |
| blk_cnt_i | input | CNT_W | Number of blocks |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | End-of-transfer pulse |
| error_o | output | 1 | Last transfer failed |
| blk_strobe_o | output | 1 | Start of one block's payload |
| blk_done_i | input | 1 | Data engine finished the block's payload |
| cmd_req_o | output | 1 | Command request, held until done |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | ARG_W | Command argument |
| cmd_done_i | input | 1 | Command finished, response valid |
| cmd_resp_i | input | 16 | Response; low byte is the R1 byte |
| tok_tx_valid_o | output | 1 | Token byte to send |
| tok_tx_byte_o | output | 8 | Token value |
| tok_tx_ready_i | input | 1 | Token byte accepted |
| rx_req_o | output | 1 | Request bytes from the card |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |

## Verification
The bench builds the block with CNT_W=3 and WAIT_LIMIT=6. This keeps every timeout boundary a few bytes away, so both the tolerated WAIT_LIMIT-1 wait and the failing WAIT_LIMIT wait fit in short scripts. The bench sweeps both directions, both capacity classes and counts 1 to 4. Block numbers include 0, all-ones and 0x7FFFFF, which reach the 32-bit truncation of the shifted address. Each failure path is then driven once on its own: status not ready, data command rejected, bad read token, read timeout, rejected data response, busy timeout and zero count.

// File: rtl/sd_xfer_pkg.sv
`timescale 1ns/1ps
package sd_xfer_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT,
        S_XCMD,
        S_RD_TOK,
        S_BLK_GO,
        S_PAYLOAD,
        S_WR_TOK,
        S_WR_RESP,
        S_WR_BUSY,
        S_STOP_CMD,
        S_STOP_TOK,
        S_STOP_BUSY,
        S_FINISH
    } xfer_state_e;

    localparam logic [5:0] CMD_STATUS   = 6'd13;
    localparam logic [5:0] CMD_RD_MULTI = 6'd18;
    localparam logic [5:0] CMD_WR_MULTI = 6'd25;
    localparam logic [5:0] CMD_STOP     = 6'd12;

    localparam logic [7:0] TOK_RD_START = 8'hFE;
    localparam logic [7:0] TOK_WR_START = 8'hFC;
    localparam logic [7:0] TOK_WR_STOP  = 8'hFD;
    localparam logic [7:0] BYTE_IDLE    = 8'hFF;
    localparam logic [7:0] BYTE_BUSY    = 8'h00;
    localparam logic [3:0] DRESP_OK     = 4'h5;

endpackage

// File: rtl/sd_xfer_addr.sv
`timescale 1ns/1ps
// Forms the data command argument from the block number and capacity class.
module sd_xfer_addr #(
    parameter int ARG_W     = 32,
    parameter int BLK_SHIFT = 9
) (
    input  logic [ARG_W-1:0] blk_num,
    input  logic             high_cap,
    output logic [ARG_W-1:0] arg
);
    logic [ARG_W-1:0] byte_addr;

    generate
        if (BLK_SHIFT == 0) begin : g_noshift
            assign byte_addr = blk_num;
        end else begin : g_shift
            assign byte_addr = {blk_num[ARG_W-1-BLK_SHIFT:0], {BLK_SHIFT{1'b0}}};
        end
    endgenerate

    assign arg = high_cap ? blk_num : byte_addr;
endmodule

// File: rtl/sd_xfer_wait.sv
`timescale 1ns/1ps
// Counts consecutive filler bytes within one wait state.
module sd_xfer_wait #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (miss)  cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CW'(LIMIT - 1));

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/sd_xfer_blkcnt.sv
`timescale 1ns/1ps
// Remaining-block counter, loaded at start, decremented per completed block.
module sd_xfer_blkcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (dec)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/sd_blk_xfer_seq.sv
`timescale 1ns/1ps
module sd_blk_xfer_seq
    import sd_xfer_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int CNT_W      = 16,
    parameter int WAIT_LIMIT = 1024,
    parameter int BLK_SHIFT  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic             high_cap_i,
    input  logic [ARG_W-1:0] blk_num_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o,
    output logic             blk_strobe_o,
    input  logic             blk_done_i,
    output logic             cmd_req_o,
    output logic [5:0]       cmd_idx_o,
    output logic [ARG_W-1:0] cmd_arg_o,
    input  logic             cmd_done_i,
    input  logic [15:0]      cmd_resp_i,
    output logic             tok_tx_valid_o,
    output logic [7:0]       tok_tx_byte_o,
    input  logic             tok_tx_ready_i,
    output logic             rx_req_o,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i
);
    xfer_state_e      state_q, state_d;
    logic             err_q, hc_q, wr_q;
    logic [ARG_W-1:0] blk_q;
    logic [ARG_W-1:0] data_arg;
    logic             fail, blk_end, miss, at_limit, last_blk, accept;

    assign accept = (state_q == S_IDLE) && start_i;

    sd_xfer_addr #(.ARG_W(ARG_W), .BLK_SHIFT(BLK_SHIFT)) addr_i (
        .blk_num (blk_q),
        .high_cap(hc_q),
        .arg     (data_arg)
    );

    sd_xfer_wait #(.LIMIT(WAIT_LIMIT)) wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .miss    (miss),
        .at_limit(at_limit)
    );

    sd_xfer_blkcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(blk_cnt_i),
        .dec     (blk_end),
        .last    (last_blk)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fail    = 1'b0;
        blk_end = 1'b0;
        miss    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (blk_cnt_i == '0) begin
                        fail    = 1'b1;
                        state_d = S_FINISH;
                    end else begin
                        state_d = S_STAT;
                    end
                end
            end
            S_STAT: begin
                if (cmd_done_i) begin
                    if (cmd_resp_i == '0) state_d = S_XCMD;
                    else begin
                        fail    = 1'b1;
                        state_d = S_FINISH;
                    end
                end
            end
            S_XCMD: begin
                if (cmd_done_i) begin
                    if (cmd_resp_i[7:0] != 8'h00) begin
                        fail    = 1'b1;
                        state_d = S_FINISH;
                    end else begin
                        state_d = wr_q ? S_WR_TOK : S_RD_TOK;
                    end
                end
            end
            S_RD_TOK: begin
                if (rx_valid_i) begin
                    if (rx_byte_i == TOK_RD_START) begin
                        state_d = S_BLK_GO;
                    end else if (rx_byte_i == BYTE_IDLE) begin
                        miss = 1'b1;
                        if (at_limit) begin
                            fail    = 1'b1;
                            state_d = S_FINISH;
                        end
                    end else begin
                        fail    = 1'b1;
                        state_d = S_FINISH;
                    end
                end
            end
            S_BLK_GO: state_d = S_PAYLOAD;
            S_PAYLOAD: begin
                if (blk_done_i) begin
                    if (wr_q) begin
                        state_d = S_WR_RESP;
                    end else begin
                        blk_end = 1'b1;
                        state_d = last_blk ? S_STOP_CMD : S_RD_TOK;
                    end
                end
            end
            S_WR_TOK: begin
                if (tok_tx_ready_i) state_d = S_BLK_GO;
            end
            S_WR_RESP: begin
                if (rx_valid_i) begin
                    if (rx_byte_i == BYTE_IDLE) begin
                        miss = 1'b1;
                        if (at_limit) begin
                            fail    = 1'b1;
                            state_d = S_FINISH;
                        end
                    end else if (rx_byte_i[3:0] == DRESP_OK) begin
                        state_d = S_WR_BUSY;
                    end else begin
                        fail    = 1'b1;
                        state_d = S_FINISH;
                    end
                end
            end
            S_WR_BUSY: begin
                if (rx_valid_i) begin
                    if (rx_byte_i == BYTE_BUSY) begin
                        miss = 1'b1;
                        if (at_limit) begin
                            fail    = 1'b1;
                            state_d = S_FINISH;
                        end
                    end else begin
                        blk_end = 1'b1;
                        state_d = last_blk ? S_STOP_TOK : S_WR_TOK;
                    end
                end
            end
            S_STOP_CMD: begin
                if (cmd_done_i) state_d = S_FINISH;
            end
            S_STOP_TOK: begin
                if (tok_tx_ready_i) state_d = S_STOP_BUSY;
            end
            S_STOP_BUSY: begin
                if (rx_valid_i) begin
                    if (rx_byte_i == BYTE_BUSY) begin
                        miss = 1'b1;
                        if (at_limit) begin
                            fail    = 1'b1;
                            state_d = S_FINISH;
                        end
                    end else begin
                        state_d = S_FINISH;
                    end
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= 1'b0;
            hc_q    <= 1'b0;
            wr_q    <= 1'b0;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hc_q  <= high_cap_i;
                wr_q  <= write_i;
                blk_q <= blk_num_i;
                err_q <= 1'b0;
            end
            if (fail) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cmd_req_o      = 1'b0;
        cmd_idx_o      = '0;
        cmd_arg_o      = '0;
        tok_tx_valid_o = 1'b0;
        tok_tx_byte_o  = '0;
        rx_req_o       = 1'b0;
        blk_strobe_o   = 1'b0;
        done_o         = 1'b0;
        unique case (state_q)
            S_STAT: begin
                cmd_req_o = 1'b1;
                cmd_idx_o = CMD_STATUS;
            end
            S_XCMD: begin
                cmd_req_o = 1'b1;
                cmd_idx_o = wr_q ? CMD_WR_MULTI : CMD_RD_MULTI;
                cmd_arg_o = data_arg;
            end
            S_STOP_CMD: begin
                cmd_req_o = 1'b1;
                cmd_idx_o = CMD_STOP;
            end
            S_RD_TOK, S_WR_RESP, S_WR_BUSY, S_STOP_BUSY: rx_req_o = 1'b1;
            S_BLK_GO: blk_strobe_o = 1'b1;
            S_WR_TOK: begin
                tok_tx_valid_o = 1'b1;
                tok_tx_byte_o  = TOK_WR_START;
            end
            S_STOP_TOK: begin
                tok_tx_valid_o = 1'b1;
                tok_tx_byte_o  = TOK_WR_STOP;
            end
            S_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o  = (state_q != S_IDLE);
    assign error_o = err_q;

    assert_one_action_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_req_o, tok_tx_valid_o, rx_req_o, blk_strobe_o}));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    assert_busy_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_err_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> done_o);

    assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error_o) |-> $past(start_i && !busy_o));

    assert_std_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !hc_q && (cmd_idx_o == CMD_RD_MULTI || cmd_idx_o == CMD_WR_MULTI))
        |-> (cmd_arg_o[8:0] == 9'd0));

    assert_stat_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && !done_o) |-> (cmd_req_o && cmd_idx_o == CMD_STATUS));
endmodule

// File: tb/sd_blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module sd_blk_xfer_seq_tb_top;
    localparam int ARG_W = 32;
    localparam int CNT_W = 3;
    localparam int WL    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0, write_i = 1'b0, high_cap_i = 1'b0;
    logic [ARG_W-1:0] blk_num_i = '0;
    logic [CNT_W-1:0] blk_cnt_i = '0;
    logic             busy_o, done_o, error_o, blk_strobe_o;
    logic             blk_done_i = 1'b0;
    logic             cmd_req_o;
    logic [5:0]       cmd_idx_o;
    logic [ARG_W-1:0] cmd_arg_o;
    logic             cmd_done_i = 1'b0;
    logic [15:0]      cmd_resp_i = '0;
    logic             tok_tx_valid_o;
    logic [7:0]       tok_tx_byte_o;
    logic             tok_tx_ready_i = 1'b1;
    logic             rx_req_o;
    logic             rx_valid_i = 1'b0;
    logic [7:0]       rx_byte_i = '0;

    always #2 clk = ~clk;

    sd_blk_xfer_seq #(.ARG_W(ARG_W), .CNT_W(CNT_W), .WAIT_LIMIT(WL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .high_cap_i(high_cap_i), .blk_num_i(blk_num_i), .blk_cnt_i(blk_cnt_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .blk_strobe_o(blk_strobe_o), .blk_done_i(blk_done_i),
        .cmd_req_o(cmd_req_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o),
        .cmd_done_i(cmd_done_i), .cmd_resp_i(cmd_resp_i),
        .tok_tx_valid_o(tok_tx_valid_o), .tok_tx_byte_o(tok_tx_byte_o),
        .tok_tx_ready_i(tok_tx_ready_i),
        .rx_req_o(rx_req_o), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i)
    );

    int n_tests = 0, n_fail = 0;

    logic [5:0]  log_idx [0:15];
    logic [31:0] log_arg [0:15];
    logic [7:0]  tx_log  [0:31];
    logic [7:0]  script  [0:255];
    int cmd_n = 0, tx_n = 0, strobes = 0, dones = 0, overlaps = 0;
    int rx_len = 0, rx_ptr = 0;
    logic [15:0] stat_resp = '0, xfer_resp = '0;

    // Command responder
    int cmd_wait = 0;
    bit cmd_act = 0;
    logic [5:0] cur_idx = '0;
    always @(negedge clk) begin
        cmd_done_i = 1'b0;
        if (!rst_n) cmd_act = 0;
        else if (cmd_act) begin
            if (cmd_wait == 0) begin
                cmd_done_i = 1'b1;
                cmd_resp_i = (cur_idx == 6'd13) ? stat_resp :
                             (cur_idx == 6'd12) ? 16'h0000 : xfer_resp;
                cmd_act = 0;
            end else cmd_wait--;
        end else if (cmd_req_o) begin
            cmd_act = 1;
            cmd_wait = 2;
            cur_idx = cmd_idx_o;
            if (cmd_n < 16) begin
                log_idx[cmd_n] = cmd_idx_o;
                log_arg[cmd_n] = cmd_arg_o;
            end
            cmd_n++;
        end
    end

    // Card byte source
    always @(negedge clk) begin
        rx_valid_i = 1'b0;
        if (rst_n && rx_req_o && rx_ptr < rx_len) begin
            rx_valid_i = 1'b1;
            rx_byte_i = script[rx_ptr];
            rx_ptr++;
        end
    end

    // Data engine model and output monitor
    int pay_wait = 0;
    bit pay_act = 0;
    always @(negedge clk) begin
        blk_done_i = 1'b0;
        if (rst_n) begin
            if (blk_strobe_o) begin
                strobes++;
                pay_act = 1;
                pay_wait = 2;
            end else if (pay_act) begin
                if (pay_wait == 0) begin
                    blk_done_i = 1'b1;
                    pay_act = 0;
                end else pay_wait--;
            end
            if (done_o) dones++;
            if (tok_tx_valid_o && tok_tx_ready_i) begin
                if (tx_n < 32) tx_log[tx_n] = tok_tx_byte_o;
                tx_n++;
            end
            if (int'(cmd_req_o) + int'(tok_tx_valid_o) + int'(rx_req_o) + int'(blk_strobe_o) > 1)
                overlaps++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        cmd_n = 0; tx_n = 0; strobes = 0; dones = 0; rx_len = 0; rx_ptr = 0;
    endtask

    task automatic push(input logic [7:0] b);
        script[rx_len] = b;
        rx_len++;
    endtask

    task automatic pulse_start(input bit hc, input bit wr, input logic [31:0] blk, input int cnt);
        @(negedge clk);
        start_i = 1'b1; write_i = wr; high_cap_i = hc;
        blk_num_i = blk; blk_cnt_i = CNT_W'(cnt);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit err);
        int n = 0;
        while (!done_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1, "R11 done reached", 32'(done_o), 1);
        err = error_o;
        @(negedge clk);
        check(busy_o == 1'b0, "R11 busy low after done", 32'(busy_o), 0);
    endtask

    bit err;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11: watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, done_o, error_o} == 3'b000, "R11 reset state", {busy_o, done_o, error_o}, 0);
        check({cmd_req_o, tok_tx_valid_o, rx_req_o, blk_strobe_o} == 4'b0, "R13 reset quiet",
              {cmd_req_o, tok_tx_valid_o, rx_req_o, blk_strobe_o}, 0);

        // Sweep of successful transfers
        for (int hc = 0; hc < 2; hc++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int cnt = 1; cnt <= 4; cnt++) begin
                    logic [31:0] blk, exp_arg;
                    blk = (cnt == 1) ? 32'hFFFF_FFFF : (cnt == 2) ? 32'h0 :
                          (cnt == 3) ? 32'h007F_FFFF : 32'h0012_3456;
                    exp_arg = hc ? blk : (blk << 9);
                    clear_logs();
                    for (int b = 0; b < cnt; b++) begin
                        if (wr == 0) begin
                            for (int k = 0; k < (b + cnt) % WL; k++) push(8'hFF);
                            push(8'hFE);
                        end else begin
                            for (int k = 0; k < b % 2; k++) push(8'hFF);
                            push((b % 2) ? 8'hE5 : 8'h05);
                            for (int k = 0; k < (b + cnt) % WL; k++) push(8'h00);
                            push(8'hFF);
                        end
                    end
                    if (wr == 1) begin
                        for (int k = 0; k < cnt % WL; k++) push(8'h00);
                        push(8'h7F);
                    end
                    pulse_start(hc[0], wr[0], blk, cnt);
                    wait_done(err);
                    check(err == 1'b0, "R12 no error on good transfer", 32'(err), 0);
                    check(cmd_n == (wr ? 2 : 3), "R10 command count", cmd_n, wr ? 2 : 3);
                    check(log_idx[0] == 6'd13 && log_arg[0] == 0, "R2 status first", log_idx[0], 13);
                    check(log_idx[1] == (wr ? 6'd25 : 6'd18), "R3 data command", log_idx[1], wr ? 25 : 18);
                    check(log_arg[1] == exp_arg, "R4 address", log_arg[1], exp_arg);
                    check(strobes == cnt, "R9 block strobes", strobes, cnt);
                    check(rx_ptr == rx_len, "R5 R8 bytes consumed", rx_ptr, rx_len);
                    check(dones == 1, "R11 one done", dones, 1);
                    if (wr == 0) begin
                        check(log_idx[2] == 6'd12 && log_arg[2] == 0, "R10 read stop command", log_idx[2], 12);
                        check(tx_n == 0, "R10 no tokens on read", tx_n, 0);
                    end else begin
                        check(tx_n == cnt + 1, "R6 token count", tx_n, cnt + 1);
                        for (int b = 0; b < cnt; b++)
                            check(tx_log[b] == 8'hFC, "R6 start token", tx_log[b], 8'hFC);
                        check(tx_log[cnt] == 8'hFD, "R10 stop token", tx_log[cnt], 8'hFD);
                    end
                end
            end
        end

        // Status not ready
        clear_logs(); stat_resp = 16'h0100;
        pulse_start(1'b0, 1'b0, 32'h10, 2);
        wait_done(err);
        check(err == 1'b1, "R2 not ready error", 32'(err), 1);
        check(cmd_n == 1, "R2 no further command", cmd_n, 1);
        check(strobes == 0, "R2 no blocks", strobes, 0);
        stat_resp = '0;

        // Data command rejected
        clear_logs(); xfer_resp = 16'h0004;
        pulse_start(1'b1, 1'b1, 32'h20, 2);
        wait_done(err);
        check(err == 1'b1, "R3 R1 reject error", 32'(err), 1);
        check(cmd_n == 2 && tx_n == 0, "R3 stops after data command", cmd_n, 2);
        xfer_resp = '0;

        // Read timeout: WL filler bytes
        clear_logs();
        for (int k = 0; k < WL; k++) push(8'hFF);
        pulse_start(1'b1, 1'b0, 32'h5, 1);
        wait_done(err);
        check(err == 1'b1, "R5 timeout error", 32'(err), 1);
        check(rx_ptr == WL, "R5 timeout byte count", rx_ptr, WL);
        check(strobes == 0 && cmd_n == 2, "R5 no block after timeout", strobes, 0);

        // Bad read token
        clear_logs();
        push(8'hFF); push(8'h09);
        pulse_start(1'b0, 1'b0, 32'h5, 1);
        wait_done(err);
        check(err == 1'b1, "R5 bad token error", 32'(err), 1);
        check(strobes == 0, "R5 no block on bad token", strobes, 0);

        // Rejected data response
        clear_logs();
        push(8'hFF); push(8'h0B);
        pulse_start(1'b0, 1'b1, 32'h7, 2);
        wait_done(err);
        check(err == 1'b1, "R7 reject error", 32'(err), 1);
        check(strobes == 1, "R7 one block sent", strobes, 1);
        check(tx_n == 1 && tx_log[0] == 8'hFC, "R7 no stop token", tx_n, 1);

        // Busy timeout
        clear_logs();
        push(8'h05);
        for (int k = 0; k < WL; k++) push(8'h00);
        pulse_start(1'b1, 1'b1, 32'h7, 1);
        wait_done(err);
        check(err == 1'b1, "R8 busy timeout error", 32'(err), 1);
        check(tx_n == 1, "R8 no stop token after timeout", tx_n, 1);

        // Zero count; error still held from previous failure
        clear_logs();
        check(error_o == 1'b1, "R12 error held while idle", 32'(error_o), 1);
        pulse_start(1'b0, 1'b0, 32'h1, 0);
        wait_done(err);
        check(err == 1'b1, "R12 zero count error", 32'(err), 1);
        check(cmd_n == 0 && dones == 1, "R12 zero count no command", cmd_n, 0);

        // Next start clears error
        clear_logs();
        push(8'hFE);
        pulse_start(1'b1, 1'b0, 32'h3, 1);
        check(error_o == 1'b0, "R12 error cleared on start", 32'(error_o), 0);
        wait_done(err);
        check(err == 1'b0, "R12 clean after clear", 32'(err), 0);

        // Start while busy is ignored
        clear_logs();
        for (int b = 0; b < 2; b++) begin push(8'h05); push(8'hFF); end
        push(8'hFF);
        pulse_start(1'b0, 1'b1, 32'h40, 2);
        repeat (5) @(negedge clk);
        start_i = 1'b1; write_i = 1'b0; high_cap_i = 1'b1; blk_num_i = 32'h99; blk_cnt_i = 3'd1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(err);
        repeat (10) @(negedge clk);
        check(err == 1'b0, "R1 transfer unaffected", 32'(err), 0);
        check(cmd_n == 2 && log_idx[1] == 6'd25, "R1 no extra command", cmd_n, 2);
        check(log_arg[1] == (32'h40 << 9), "R1 address kept", log_arg[1], 32'h40 << 9);
        check(strobes == 2 && dones == 1, "R1 blocks and dones", strobes, 2);

        check(overlaps == 0, "R13 exclusive actions", overlaps, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule